// File: doc/BRIEF.md
# Token-Passing Readout Sequencer

This block is one node of a daisy chain of compressor units. All the nodes share a single 32-bit output bus that feeds a receiving FIFO. A node transmits only while it holds a token. When the token arrives, the node records how many words its local FIFO holds at that moment and reads them out in order. It places each word on the bus for a fixed slot of ten clock cycles and marks the word with a strobe pulse inside the slot. When the last word of its share has been sent, the node hands the token to the next node.

The receiver paces the transfer with a ready signal. At each slot boundary the node checks that signal. If it is low, the node keeps the current word on the bus with the strobe low and starts no new slot until the signal returns high. If the node finds its FIFO empty when the token arrives, it forwards the token almost at once, so a quiet node costs the chain only a few cycles per turn. Words that reach the FIFO after the token arrived stay there until the next turn.

The local FIFO is assumed to have one cycle of read latency. Data requested with `fifo_rd` is valid on `fifo_data` in the following cycle.

Top module: `token_readout_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `tok_out`, `bus_stb` and `fifo_rd` are 0 and `bus_data` is 0.
- R2: If `tok_in` is sampled high with `fifo_empty` high, `tok_out` goes high on the second rising edge after that sample and stays high for one cycle. No read is issued and no strobe occurs.
- R3: The number of words sent in a turn equals `fifo_level` at the edge that samples `tok_in`, or 0 if `fifo_empty` is high at that edge. Words written later stay in the FIFO for the next turn.
- R4: Words go out in FIFO order, one per slot. While `rx_next` stays high, consecutive words start exactly SLOT_CYC (10) cycles apart.
- R5: Number the cycles of a slot from 0, where cycle 0 is the first cycle with the new word on `bus_data`. `bus_stb` is high in slot cycles STB_FIRST to STB_LAST (2 to 4) and low at all other times.
- R6: `bus_data` changes only at the start of a slot. It holds its value through the slot and after it until the next word starts.
- R7: If `rx_next` is low at a slot boundary, no new word starts and `bus_stb` stays low. The next word starts on the edge that samples `rx_next` high.
- R8: After the last word of a turn, `tok_out` goes high for exactly one cycle. It rises SLOT_CYC cycles after that word's slot began.
- R9: `fifo_rd` is never high while `fifo_empty` is high. A turn issues exactly as many reads as words it sends.
- R10: A `tok_in` pulse that arrives while the node already holds the token has no effect. The turn sends no extra words and `tok_out` pulses only once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (50 MHz nominal, 20 ns per cycle) |
| rst | input | 1 | Synchronous active-high reset |
| tok_in | input | 1 | Token from the previous node, one-cycle pulse |
| tok_out | output | 1 | Token to the next node, one-cycle pulse |
| fifo_empty | input | 1 | Local FIFO holds no word |
| fifo_level | input | LVL_W (10) | Number of words in the local FIFO |
| fifo_rd | output | 1 | Read request to the local FIFO |
| fifo_data | input | DATA_W (32) | Local FIFO read data, valid one cycle after `fifo_rd` |
| bus_data | output | DATA_W (32) | Word driven onto the shared bus |
| bus_stb | output | 1 | Data strobe inside each slot |
| rx_next | input | 1 | Receiver ready; gates the start of each new word |

## Verification
The bench targets these corner cases:

- **Empty FIFO at token arrival.** A node that did not short-circuit this case would waste a slot, read an empty FIFO, or pulse the strobe.
- **Words written in the middle of a turn.** A node that tracked the live level instead of a snapshot would send them early and delay the token.
- **Receiver ready dropped at a slot boundary.** A design that ignored the stall would start a word the receiver cannot take. A design with a faulty prefetch path would corrupt or repeat the held word.
- **Stray token pulse during a turn.** A design that accepted it would reload the word count and run past its share.

Across all of these, the bench also measures slot spacing, strobe position and token timing to the cycle.

// File: rtl/readout_pkg.sv
package readout_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_GRANT,
        SQ_FETCH_RD,
        SQ_FETCH_CAP,
        SQ_HOLD,
        SQ_SLOT,
        SQ_PASS
    } seq_state_t;

    // Decoded position inside a transfer slot
    typedef struct packed {
        logic strobe;
        logic pre_rd;
        logic pre_cap;
        logic boundary;
    } slot_flags_t;

    // Control strobes issued by the sequencing FSM
    typedef struct packed {
        logic load;
        logic launch;
        logic rd;
        logic cap;
        logic run;
    } seq_ctrl_t;

    function automatic logic in_window(input int unsigned pos,
                                       input int unsigned lo,
                                       input int unsigned hi);
        return (pos >= lo) && (pos <= hi);
    endfunction

endpackage

// File: rtl/rd_slot_timer.sv
module rd_slot_timer
    import readout_pkg::*;
#(
    parameter int unsigned SLOT_CYC  = 10,
    parameter int unsigned STB_FIRST = 2,
    parameter int unsigned STB_LAST  = 4
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        run,
    input  logic        restart,
    output slot_flags_t flags
);
    localparam int unsigned CNT_W = $clog2(SLOT_CYC);
    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(SLOT_CYC - 1);
    localparam logic [CNT_W-1:0] RD_POS   = CNT_W'(SLOT_CYC - 3);
    localparam logic [CNT_W-1:0] CAP_POS  = CNT_W'(SLOT_CYC - 2);

    logic [CNT_W-1:0] pos;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos <= '0;
        end else if (restart) begin
            pos <= '0;
        end else if (run && pos != LAST_POS) begin
            pos <= pos + 1'b1;
        end
    end

    always_comb begin
        flags.strobe   = run && in_window(32'(pos), STB_FIRST, STB_LAST);
        flags.pre_rd   = run && (pos == RD_POS);
        flags.pre_cap  = run && (pos == CAP_POS);
        flags.boundary = run && (pos == LAST_POS);
    end

endmodule

// File: rtl/rd_word_budget.sv
module rd_word_budget #(
    parameter int unsigned LVL_W = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [LVL_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);
    logic [LVL_W-1:0] remaining;

    always_ff @(posedge clk) begin
        if (rst) begin
            remaining <= '0;
        end else if (load) begin
            remaining <= load_val;
        end else if (dec && remaining != '0) begin
            remaining <= remaining - 1'b1;
        end
    end

    assign zero = (remaining == '0);

endmodule

// File: rtl/rd_token_fsm.sv
module rd_token_fsm
    import readout_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tok_in,
    input  logic       budget_zero,
    input  logic       boundary,
    input  logic       pre_rd,
    input  logic       pre_cap,
    input  logic       rx_next,
    output seq_state_t state,
    output seq_ctrl_t  ctrl,
    output logic       tok_out
);
    seq_state_t state_nx;

    always_ff @(posedge clk) begin
        if (rst) state <= SQ_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_IDLE:      if (tok_in) state_nx = SQ_GRANT;
            SQ_GRANT:     state_nx = budget_zero ? SQ_PASS : SQ_FETCH_RD;
            SQ_FETCH_RD:  state_nx = SQ_FETCH_CAP;
            SQ_FETCH_CAP: state_nx = SQ_HOLD;
            SQ_HOLD:      if (rx_next) state_nx = SQ_SLOT;
            SQ_SLOT: begin
                if (boundary) begin
                    if (budget_zero)  state_nx = SQ_PASS;
                    else if (!rx_next) state_nx = SQ_HOLD;
                end
            end
            SQ_PASS:      state_nx = SQ_IDLE;
            default:      state_nx = SQ_IDLE;
        endcase
    end

    always_comb begin
        ctrl.run    = (state == SQ_SLOT);
        ctrl.load   = (state == SQ_IDLE) && tok_in;
        ctrl.launch = ((state == SQ_HOLD) && rx_next) ||
                      ((state == SQ_SLOT) && boundary && !budget_zero && rx_next);
        ctrl.rd     = (state == SQ_FETCH_RD) ||
                      ((state == SQ_SLOT) && pre_rd && !budget_zero);
        ctrl.cap    = (state == SQ_FETCH_CAP) ||
                      ((state == SQ_SLOT) && pre_cap && !budget_zero);
    end

    assign tok_out = (state == SQ_PASS);

endmodule

// File: rtl/token_readout_seq.sv
module token_readout_seq
    import readout_pkg::*;
#(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned LVL_W     = 10,
    parameter int unsigned SLOT_CYC  = 10,
    parameter int unsigned STB_FIRST = 2,
    parameter int unsigned STB_LAST  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tok_in,
    output logic              tok_out,
    input  logic              fifo_empty,
    input  logic [LVL_W-1:0]  fifo_level,
    output logic              fifo_rd,
    input  logic [DATA_W-1:0] fifo_data,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_stb,
    input  logic              rx_next
);
    seq_state_t       state;
    seq_ctrl_t        ctrl;
    slot_flags_t      flags;
    logic             budget_zero;
    logic [LVL_W-1:0] snap_val;
    logic [DATA_W-1:0] stage_q;
    logic             launch_w;
    logic             st_idle;

    // Word count is frozen at token arrival; an empty FIFO counts as zero
    assign snap_val = fifo_empty ? '0 : fifo_level;

    rd_slot_timer #(
        .SLOT_CYC (SLOT_CYC),
        .STB_FIRST(STB_FIRST),
        .STB_LAST (STB_LAST)
    ) i_timer (
        .clk    (clk),
        .rst    (rst),
        .run    (ctrl.run),
        .restart(ctrl.launch),
        .flags  (flags)
    );

    rd_word_budget #(
        .LVL_W(LVL_W)
    ) i_budget (
        .clk     (clk),
        .rst     (rst),
        .load    (ctrl.load),
        .load_val(snap_val),
        .dec     (ctrl.launch),
        .zero    (budget_zero)
    );

    rd_token_fsm i_fsm (
        .clk        (clk),
        .rst        (rst),
        .tok_in     (tok_in),
        .budget_zero(budget_zero),
        .boundary   (flags.boundary),
        .pre_rd     (flags.pre_rd),
        .pre_cap    (flags.pre_cap),
        .rx_next    (rx_next),
        .state      (state),
        .ctrl       (ctrl),
        .tok_out    (tok_out)
    );

    // Staging register lets the next word be fetched during the current slot
    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q  <= '0;
            bus_data <= '0;
        end else begin
            if (ctrl.cap)    stage_q  <= fifo_data;
            if (ctrl.launch) bus_data <= stage_q;
        end
    end

    assign fifo_rd  = ctrl.rd;
    assign bus_stb  = flags.strobe;
    assign launch_w = ctrl.launch;
    assign st_idle  = (state == SQ_IDLE);

endmodule

// File: rtl/readout_seq_checker.sv
module readout_seq_checker #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned SLOT_CYC  = 10,
    parameter int unsigned STB_FIRST = 2,
    parameter int unsigned STB_LAST  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              tok_in,
    input logic              tok_out,
    input logic              fifo_empty,
    input logic              fifo_rd,
    input logic [DATA_W-1:0] bus_data,
    input logic              bus_stb,
    input logic              rx_next,
    input logic              launch,
    input logic              idle
);
    localparam int unsigned AGE_W = $clog2(SLOT_CYC + 1);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(SLOT_CYC);

    logic [AGE_W-1:0] age;

    always_ff @(posedge clk) begin
        if (rst)               age <= AGE_MAX;
        else if (launch)       age <= '0;
        else if (age != AGE_MAX) age <= age + 1'b1;
    end

    assert_fast_pass_R2: assert property (@(posedge clk) disable iff (rst)
        (idle && tok_in && fifo_empty) |-> ##2 tok_out);

    assert_slot_gap_R4: assert property (@(posedge clk) disable iff (rst)
        launch |-> (age >= AGE_W'(SLOT_CYC - 1)));

    assert_stb_window_R5: assert property (@(posedge clk) disable iff (rst)
        bus_stb |-> (age >= AGE_W'(STB_FIRST) && age <= AGE_W'(STB_LAST)));

    assert_data_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !launch |=> $stable(bus_data));

    assert_next_gate_R7: assert property (@(posedge clk) disable iff (rst)
        launch |-> rx_next);

    assert_tok_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        tok_out |=> !tok_out);

    assert_no_empty_read_R9: assert property (@(posedge clk) disable iff (rst)
        fifo_rd |-> !fifo_empty);

endmodule

bind token_readout_seq readout_seq_checker #(
    .DATA_W   (DATA_W),
    .SLOT_CYC (SLOT_CYC),
    .STB_FIRST(STB_FIRST),
    .STB_LAST (STB_LAST)
) i_chk (
    .clk       (clk),
    .rst       (rst),
    .tok_in    (tok_in),
    .tok_out   (tok_out),
    .fifo_empty(fifo_empty),
    .fifo_rd   (fifo_rd),
    .bus_data  (bus_data),
    .bus_stb   (bus_stb),
    .rx_next   (rx_next),
    .launch    (launch_w),
    .idle      (st_idle)
);

// File: tb/test_token_readout_seq.sv
module test_token_readout_seq;
    localparam int SLOT = 10;
    localparam int SF   = 2;
    localparam int SL   = 4;
    localparam int DW   = 32;
    localparam int LW   = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tok_in = 1'b0;
    logic rx_next = 1'b1;
    logic tok_out, fifo_empty, fifo_rd, bus_stb;
    logic [LW-1:0] fifo_level;
    logic [DW-1:0] fifo_data, bus_data;

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;

    // FIFO model with one cycle read latency
    logic [DW-1:0] mem [0:1023];
    int n_push = 0;
    int n_pop  = 0;
    assign fifo_level = LW'(n_push - n_pop);
    assign fifo_empty = (n_push == n_pop);
    always @(posedge clk) begin
        if (fifo_rd) begin
            fifo_data <= mem[n_pop % 1024];
            n_pop     <= n_pop + 1;
        end
    end

    token_readout_seq i_token_readout_seq (
        .clk       (clk),
        .rst       (rst),
        .tok_in    (tok_in),
        .tok_out   (tok_out),
        .fifo_empty(fifo_empty),
        .fifo_level(fifo_level),
        .fifo_rd   (fifo_rd),
        .fifo_data (fifo_data),
        .bus_data  (bus_data),
        .bus_stb   (bus_stb),
        .rx_next   (rx_next)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Bus monitor, samples at the falling edge
    logic [DW-1:0] rx_buf [0:255];
    int rx_n = 0;
    int tok_cnt = 0;
    int cyc = 0;
    int chg_cyc = 0;
    int last_rise = 0;
    int stb_len = 0;
    bit have_rise = 0;
    bit dropped = 0;
    bit prev_stb = 0;
    bit prev_tok = 0;
    logic [DW-1:0] prev_data = '0;
    logic [2:0] nx_hist = '0;

    always @(negedge clk) begin
        cyc++;
        if (rst) begin
            have_rise = 0;
            dropped   = 0;
            prev_stb  = 0;
            prev_tok  = 0;
            stb_len   = 0;
            prev_data = bus_data;
        end else begin
            if (bus_data !== prev_data) chg_cyc = cyc;
            if (have_rise && chg_cyc <= last_rise &&
                (cyc - last_rise) >= (SLOT - SF - 1) && !rx_next)
                dropped = 1;
            if (bus_stb && !prev_stb) begin
                rx_buf[rx_n % 256] = bus_data;
                rx_n++;
                chk(cyc - chg_cyc == SF, "R6 word settled before strobe",
                    64'(cyc - chg_cyc), 64'(SF));
                chk(nx_hist[2] == 1'b1, "R7 word started with ready high",
                    64'(nx_hist[2]), 64'd1);
                if (have_rise) begin
                    if (!dropped)
                        chk(cyc - last_rise == SLOT, "R4 slot spacing",
                            64'(cyc - last_rise), 64'(SLOT));
                    else
                        chk(cyc - last_rise > SLOT, "R7 stalled slot longer",
                            64'(cyc - last_rise), 64'(SLOT + 1));
                end
                have_rise = 1;
                last_rise = cyc;
                dropped   = 0;
                stb_len   = 0;
            end
            if (bus_stb) stb_len++;
            if (!bus_stb && prev_stb)
                chk(stb_len == SL - SF + 1, "R5 strobe width",
                    64'(stb_len), 64'(SL - SF + 1));
            if (fifo_rd)
                chk(!fifo_empty, "R9 read while empty", 64'(fifo_empty), 64'd0);
            if (tok_out && prev_tok)
                chk(1'b0, "R8 token pulse wider than one cycle", 64'd2, 64'd1);
            if (tok_out && !prev_tok) begin
                tok_cnt++;
                if (have_rise)
                    chk(cyc - last_rise == SLOT - SF, "R8 token after last slot",
                        64'(cyc - last_rise), 64'(SLOT - SF));
                have_rise = 0;
            end
            prev_stb  = bus_stb;
            prev_tok  = tok_out;
            prev_data = bus_data;
        end
        nx_hist = {nx_hist[1:0], rx_next};
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic push(input logic [DW-1:0] w);
        mem[n_push % 1024] = w;
        n_push++;
    endtask

    task automatic give_token();
        step();
        tok_in = 1'b1;
        step();
        tok_in = 1'b0;
    endtask

    task automatic wait_pass(input int base);
        for (int i = 0; i < 3000; i++) begin
            if (tok_cnt > base) break;
            step();
        end
        chk(tok_cnt > base, "R8 token passed", 64'(tok_cnt), 64'(base + 1));
    endtask

    function automatic logic [DW-1:0] word_of(input int tag, input int i);
        return 32'hA500_0000 + 32'(tag * 256 + i + 1);
    endfunction

    task automatic check_words(input int base, input int n, input int tag,
                               input int first);
        for (int i = 0; i < n; i++)
            chk(rx_buf[(base + i) % 256] == word_of(tag, first + i),
                "R4 word order", 64'(rx_buf[(base + i) % 256]),
                64'(word_of(tag, first + i)));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) step();
        chk(tok_out == 1'b0, "R1 tok_out in reset", 64'(tok_out), 64'd0);
        chk(bus_stb == 1'b0, "R1 strobe in reset", 64'(bus_stb), 64'd0);
        chk(fifo_rd == 1'b0, "R1 read in reset", 64'(fifo_rd), 64'd0);
        chk(bus_data == '0, "R1 bus data in reset", 64'(bus_data), 64'd0);
        rst = 1'b0;
        step();
        chk(tok_out == 1'b0 && bus_stb == 1'b0 && fifo_rd == 1'b0,
            "R1 idle after reset", 64'({tok_out, bus_stb, fifo_rd}), 64'd0);
    endtask

    task automatic t_empty();
        int p0 = n_pop;
        step();
        tok_in = 1'b1;
        step();
        tok_in = 1'b0;
        chk(tok_out == 1'b0, "R2 no token yet", 64'(tok_out), 64'd0);
        step();
        chk(tok_out == 1'b1, "R2 token after two edges", 64'(tok_out), 64'd1);
        step();
        chk(tok_out == 1'b0, "R2 token one cycle", 64'(tok_out), 64'd0);
        chk(n_pop == p0, "R2 no read on empty", 64'(n_pop), 64'(p0));
        chk(bus_stb == 1'b0, "R2 no strobe", 64'(bus_stb), 64'd0);
    endtask

    task automatic t_turn(input int n, input int tag);
        int base = rx_n;
        int tb   = tok_cnt;
        for (int i = 0; i < n; i++) push(word_of(tag, i));
        give_token();
        wait_pass(tb);
        step();
        chk(rx_n - base == n, "R3 word count", 64'(rx_n - base), 64'(n));
        check_words(base, n, tag, 0);
        chk(fifo_empty == 1'b1, "R9 all read", 64'(fifo_empty), 64'd1);
    endtask

    task automatic t_snapshot();
        int base = rx_n;
        int tb   = tok_cnt;
        for (int i = 0; i < 3; i++) push(word_of(7, i));
        give_token();
        repeat (15) step();
        push(word_of(7, 3));
        push(word_of(7, 4));
        wait_pass(tb);
        step();
        chk(rx_n - base == 3, "R3 snapshot count", 64'(rx_n - base), 64'd3);
        chk(fifo_level == 2, "R3 late words kept", 64'(fifo_level), 64'd2);
        check_words(base, 3, 7, 0);
        give_token();
        wait_pass(tb + 1);
        step();
        chk(rx_n - base == 5, "R3 late words next turn", 64'(rx_n - base), 64'd5);
        check_words(base + 3, 2, 7, 3);
    endtask

    task automatic t_stall();
        int base = rx_n;
        int tb   = tok_cnt;
        for (int i = 0; i < 3; i++) push(word_of(9, i));
        give_token();
        for (int i = 0; i < 100; i++) begin
            if (rx_n - base >= 1) break;
            step();
        end
        rx_next = 1'b0;
        repeat (30) step();
        chk(rx_n - base == 1, "R7 no word while not ready", 64'(rx_n - base), 64'd1);
        chk(bus_stb == 1'b0, "R7 strobe low in stall", 64'(bus_stb), 64'd0);
        chk(bus_data == word_of(9, 0), "R6 word held in stall",
            64'(bus_data), 64'(word_of(9, 0)));
        chk(tok_out == 1'b0, "R7 token held in stall", 64'(tok_out), 64'd0);
        rx_next = 1'b1;
        wait_pass(tb);
        step();
        chk(rx_n - base == 3, "R7 resumed count", 64'(rx_n - base), 64'd3);
        check_words(base, 3, 9, 0);
    endtask

    task automatic t_ignore();
        int base = rx_n;
        int tb   = tok_cnt;
        int p0   = n_pop;
        for (int i = 0; i < 4; i++) push(word_of(11, i));
        give_token();
        repeat (12) step();
        tok_in = 1'b1;
        step();
        tok_in = 1'b0;
        wait_pass(tb);
        repeat (40) step();
        chk(tok_cnt == tb + 1, "R10 single token pass", 64'(tok_cnt), 64'(tb + 1));
        chk(rx_n - base == 4, "R10 no extra words", 64'(rx_n - base), 64'd4);
        chk(n_pop - p0 == 4, "R9 reads equal words", 64'(n_pop - p0), 64'd4);
        check_words(base, 4, 11, 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_empty();
        t_turn(4, 1);
        t_turn(1, 2);
        t_snapshot();
        t_stall();
        t_ignore();
        t_turn(20, 3);
        t_empty();
        repeat (5) step();
        summary();
        $finish;
    end

endmodule